// File: doc/BRIEF.md
# EEPROM Status and Write-Guard Unit

This unit holds the status byte of a serial EEPROM and decides whether a write may proceed. It keeps a busy flag, a write-enable latch, a two-bit block-protect code and a status-lock bit. It combines them with a live, active-low protect pin to rule on each array write or status write that the command decoder presents. Shifting of serial bits and the memory array itself sit outside this unit. The unit does not time the write cycle. It starts the busy flag when it accepts a write, and it clears the flag when the external cycle timer pulses `cycle_done`.

A command is presented for one clock with `cmd_go` high. `cmd_is_sr` selects a status write (1) or an array write (0). The verdict appears one clock later as a single-cycle pulse on `wr_ok`, `sr_ok` or `rej`. A new status value is held aside and loaded into the status byte only when the cycle completes, so the old protection stays in force during that cycle.

Top module: `sr_guard`

## Requirements
- R1: After reset, `status` reads 8'h00 and `wr_ok`, `sr_ok` and `rej` are 0.
- R2: `status` is laid out as {lock, 3'b000, bp[1:0], wel, busy}. Bit 7 is the lock, bits 6..4 always read 0, bits 3..2 are the protect code, bit 1 is the enable latch and bit 0 is busy.
- R3: A `wel_set` pulse sets bit 1 and a `wel_clr` pulse clears it. When both are high in the same cycle, the clear wins.
- R4: An accepted write gives a one-cycle pulse on `wr_ok` (array) or `sr_ok` (status) in the cycle after `cmd_go`. Busy (bit 0) reads 1 from that same cycle.
- R5: A status write takes only data bits 7, 3 and 2. Those bits load into status bits 7, 3 and 2 only when the cycle completes, and until then the old values read back unchanged.
- R6: A `cycle_done` pulse while busy clears both busy and the enable latch in the next cycle. The latch is cleared even if `wel_set` is high in the same cycle.
- R7: `hw_locked` = lock bit AND NOT `wp_n`. The lock can be entered in either order and is left only by raising `wp_n`. While it is set, a status write is rejected even with the latch set.
- R8: Any write is rejected if the enable latch is clear or if a cycle is busy.
- R9: An array write is rejected when its page lies in the protected range. With the default 13-bit address, code 01 protects 0x1800..0x1FFF, code 10 protects 0x1000..0x1FFF, code 11 protects all addresses and code 00 protects none.
- R10: A rejected command gives a one-cycle `rej` pulse, leaves the enable latch unchanged and does not start busy. At most one of `wr_ok`, `sr_ok` and `rej` is high in any cycle.
- R11: A `cycle_done` pulse while not busy changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wel_set | input | 1 | Set the write-enable latch |
| wel_clr | input | 1 | Clear the write-enable latch |
| cmd_go | input | 1 | Present a write command for one cycle |
| cmd_is_sr | input | 1 | 1 = status write, 0 = array write |
| cmd_addr | input | AW | Target array address |
| cmd_data | input | 8 | Status data for a status write |
| wp_n | input | 1 | Protect pin, active low |
| cycle_done | input | 1 | End of the timed write cycle |
| status | output | 8 | Assembled status byte |
| wr_ok | output | 1 | Array write accepted (pulse) |
| sr_ok | output | 1 | Status write accepted (pulse) |
| rej | output | 1 | Command rejected (pulse) |
| hw_locked | output | 1 | Hardware-protected mode active |

## Verification
The bench builds the unit with its defaults, AW = 13 and PW = 5, which gives an 8K array made of 32-byte pages. With these values the quarter and half boundaries sit at 0x1800 and 0x1000. The bench writes on both sides of each boundary, for example 0x17FF against 0x1800 and 0x0FFF against 0x1000. It enters the lock in both orders, with the pin lowered first and with the lock bit set first, and checks that the old protection stays in force while a status write is busy.

// File: rtl/sr_guard.sv
module sr_guard #(
  parameter int AW = 13,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wel_set,
  input  logic          wel_clr,
  input  logic          cmd_go,
  input  logic          cmd_is_sr,
  input  logic [AW-1:0] cmd_addr,
  input  logic [7:0]    cmd_data,
  input  logic          wp_n,
  input  logic          cycle_done,
  output logic [7:0]    status,
  output logic          wr_ok,
  output logic          sr_ok,
  output logic          rej,
  output logic          hw_locked
);
  localparam int PGW = AW - PW;

  logic       lock_q, wel_q, busy_q, pend_q;
  logic [1:0] bp_q;
  logic [2:0] new_q;
  logic [PGW-1:0] page;
  logic       page_prot, acc_wr, acc_sr;

  assign page      = cmd_addr[AW-1:PW];
  assign hw_locked = lock_q & ~wp_n;
  assign status    = {lock_q, 3'b000, bp_q, wel_q, busy_q};

  always_comb begin
    case (bp_q)
      2'b00:   page_prot = 1'b0;
      2'b01:   page_prot = &page[PGW-1:PGW-2];
      2'b10:   page_prot = page[PGW-1];
      default: page_prot = 1'b1;
    endcase
  end

  assign acc_wr = cmd_go & ~cmd_is_sr & wel_q & ~busy_q & ~page_prot;
  assign acc_sr = cmd_go &  cmd_is_sr & wel_q & ~busy_q & ~hw_locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      bp_q   <= 2'b00;
      wel_q  <= 1'b0;
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      new_q  <= 3'b000;
      wr_ok  <= 1'b0;
      sr_ok  <= 1'b0;
      rej    <= 1'b0;
    end else begin
      wr_ok <= acc_wr;
      sr_ok <= acc_sr;
      rej   <= cmd_go & ~(acc_wr | acc_sr);
      if (busy_q && cycle_done) begin
        busy_q <= 1'b0;
        wel_q  <= 1'b0;
        pend_q <= 1'b0;
        if (pend_q) {lock_q, bp_q} <= new_q;
      end else begin
        if (acc_wr || acc_sr) busy_q <= 1'b1;
        if (acc_sr) begin
          pend_q <= 1'b1;
          new_q  <= {cmd_data[7], cmd_data[3], cmd_data[2]};
        end
        if (wel_clr)      wel_q <= 1'b0;
        else if (wel_set) wel_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sr_guard_chk.sv
module sr_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_go,
  input logic       cmd_is_sr,
  input logic       cycle_done,
  input logic [7:0] status,
  input logic       wr_ok,
  input logic       sr_ok,
  input logic       rej,
  input logic       hw_locked
);
  AST_ZERO_FIELD: assert property (@(posedge clk) disable iff (!rst_n) status[6:4] == 3'b000); // R2
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({wr_ok, sr_ok, rej})); // R10
  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (wr_ok || sr_ok) |-> status[0]); // R4
  AST_REJ_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (rej && !$past(status[0])) |-> !status[0]); // R10
  AST_LOCK_REJECTS: assert property (@(posedge clk) disable iff (!rst_n) (cmd_go && cmd_is_sr && hw_locked) |=> !sr_ok); // R7
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (cycle_done && status[0]) |=> (!status[0] && !status[1])); // R6
  AST_PROT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (status[0] && $past(status[0])) |-> status[7:2] == $past(status[7:2])); // R5
  AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n) (cycle_done && !status[0] && !cmd_go) |=> !status[0]); // R11
endmodule

bind sr_guard sr_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_is_sr(cmd_is_sr),
  .cycle_done(cycle_done), .status(status), .wr_ok(wr_ok), .sr_ok(sr_ok),
  .rej(rej), .hw_locked(hw_locked)
);

// File: tb/sr_guard_bench.sv
module sr_guard_bench;
  logic clk = 0, rst_n = 0;
  logic wel_set = 0, wel_clr = 0, cmd_go = 0, cmd_is_sr = 0, wp_n = 1, cycle_done = 0;
  logic [12:0] cmd_addr = '0;
  logic [7:0]  cmd_data = '0;
  logic [7:0]  status;
  logic wr_ok, sr_ok, rej, hw_locked;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  sr_guard u_sr_guard (
    .clk(clk), .rst_n(rst_n), .wel_set(wel_set), .wel_clr(wel_clr),
    .cmd_go(cmd_go), .cmd_is_sr(cmd_is_sr), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .wp_n(wp_n), .cycle_done(cycle_done), .status(status), .wr_ok(wr_ok),
    .sr_ok(sr_ok), .rej(rej), .hw_locked(hw_locked)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic strobe(input bit s, input bit c, input bit d);
    @(negedge clk); wel_set = s; wel_clr = c; cycle_done = d;
    @(negedge clk); wel_set = 0; wel_clr = 0; cycle_done = 0;
  endtask

  task automatic issue(input bit sr, input logic [12:0] a, input logic [7:0] d, output logic [2:0] v);
    @(negedge clk); cmd_go = 1; cmd_is_sr = sr; cmd_addr = a; cmd_data = d;
    @(negedge clk); v = {wr_ok, sr_ok, rej}; cmd_go = 0;
  endtask

  task automatic arr_try(input string tag, input logic [12:0] a, input bit expect_ok);
    logic [2:0] v;
    strobe(1, 0, 0);
    issue(0, a, 8'h00, v);
    chk(tag, {5'b0, v}, expect_ok ? 8'h04 : 8'h01);
    if (expect_ok) strobe(0, 0, 1); else strobe(0, 1, 0);
  endtask

  task automatic t_reset;
    chk("R1 status", status, 8'h00);
    chk("R1 verdicts", {5'b0, wr_ok, sr_ok, rej}, 8'h00);
  endtask

  task automatic t_latch;
    strobe(1, 0, 0); chk("R3 set", status, 8'h02);
    strobe(0, 1, 0); chk("R3 clr", status, 8'h00);
    strobe(1, 1, 0); chk("R3 clr wins", status, 8'h00);
  endtask

  task automatic t_array_basic;
    logic [2:0] v;
    issue(0, 13'h0123, 8'h00, v);
    chk("R8 no latch rej", {5'b0, v}, 8'h01);
    chk("R10 no busy", status, 8'h00);
    strobe(1, 0, 0);
    issue(0, 13'h0123, 8'h00, v);
    chk("R4 wr_ok", {5'b0, v}, 8'h04);
    chk("R4 busy", status, 8'h03);
    issue(0, 13'h0040, 8'h00, v);
    chk("R8 busy rej", {5'b0, v}, 8'h01);
    chk("R10 busy kept", status, 8'h03);
    strobe(1, 0, 1);
    chk("R6 done clears", status, 8'h00);
  endtask

  task automatic t_idle_done;
    strobe(1, 0, 0);
    strobe(0, 0, 1);
    chk("R11 idle done", status, 8'h02);
    strobe(0, 1, 0);
  endtask

  task automatic t_status_write;
    logic [2:0] v;
    strobe(1, 0, 0);
    issue(1, 13'h0, 8'hFF, v);
    chk("R4 sr_ok", {5'b0, v}, 8'h02);
    chk("R5 old bits held", status, 8'h03);
    issue(0, 13'h0, 8'h00, v);
    chk("R8 rej during sr", {5'b0, v}, 8'h01);
    strobe(0, 0, 1);
    chk("R5 R2 applied", status, 8'h8C);
    arr_try("R9 code11 0x0000", 13'h0000, 0);
    chk("R10 latch kept", status, 8'h8C);
  endtask

  task automatic t_hpm_pin_second;
    logic [2:0] v;
    @(negedge clk); wp_n = 0;
    @(negedge clk); chk("R7 locked", {7'b0, hw_locked}, 8'h01);
    strobe(1, 0, 0);
    issue(1, 13'h0, 8'h00, v);
    chk("R7 sr rej", {5'b0, v}, 8'h01);
    chk("R10 latch unchanged", status, 8'h8E);
    @(negedge clk); wp_n = 1;
    @(negedge clk); chk("R7 unlocked", {7'b0, hw_locked}, 8'h00);
    issue(1, 13'h0, 8'h04, v);
    chk("R7 sr accepted", {5'b0, v}, 8'h02);
    strobe(0, 0, 1);
    chk("R5 code01", status, 8'h04);
  endtask

  task automatic t_ranges;
    logic [2:0] v;
    arr_try("R9 01 below", 13'h17FF, 1);
    arr_try("R9 01 at", 13'h1800, 0);
    strobe(1, 0, 0);
    issue(1, 13'h0, 8'h08, v);
    strobe(0, 0, 1);
    chk("R5 code10", status, 8'h08);
    arr_try("R9 10 below", 13'h0FFF, 1);
    arr_try("R9 10 at", 13'h1000, 0);
    strobe(1, 0, 0);
    issue(1, 13'h0, 8'h00, v);
    strobe(0, 0, 1);
    arr_try("R9 00 top", 13'h1FFF, 1);
  endtask

  task automatic t_hpm_pin_first;
    logic [2:0] v;
    @(negedge clk); wp_n = 0;
    strobe(1, 0, 0);
    issue(1, 13'h0, 8'h80, v);
    chk("R7 pin first accept", {5'b0, v}, 8'h02);
    chk("R7 not yet locked", {7'b0, hw_locked}, 8'h00);
    strobe(0, 0, 1);
    chk("R7 now locked", {7'b0, hw_locked}, 8'h01);
    strobe(1, 0, 0);
    issue(1, 13'h0, 8'h00, v);
    chk("R7 locked rej", {5'b0, v}, 8'h01);
    chk("R7 lock bit kept", status, 8'h82);
    @(negedge clk); wp_n = 1;
    @(negedge clk); chk("R7 pin high exits", {7'b0, hw_locked}, 8'h00);
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_latch;
    t_array_basic;
    t_idle_done;
    t_status_write;
    t_hpm_pin_second;
    t_ranges;
    t_hpm_pin_first;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule